// File: doc/BRIEF.md
# Triple Frame Buffer Rotation Controller

This block decides who owns each of three frame buffers shared by a video source that writes whole frames and a display scan-out that reads them. Each buffer holds one of four roles: free (may be given to the writer next), filling (owned by the writer), ready (a complete frame waiting to be shown) or showing (owned by the reader). The reader only ever receives a completely written frame, so the image never tears. This holds whatever the ratio between the writer's frame rate and the reader's refresh rate.

The writer pulses `wr_done` for one cycle when it has finished a whole frame. The reader pulses `rd_frame` for one cycle at each of its frame boundaries. The block answers with the buffer index to write, the buffer index to show, a flag telling whether any frame is available for display yet, and the 2-bit role code of every buffer. Pixel storage, addressing and video timing are handled elsewhere.

Top module: `tribuf_rotator`

## Requirements
- R1: While `rst` is high at a rising edge, buffer 0 becomes filling (01) and buffers 1 and 2 become free (00); `wr_idx` = 0, `rd_idx` = 0 and `rd_valid` = 0.
- R2: Role codes are free = 00, filling = 01, showing = 10, ready = 11. Buffer i's code appears on `buf_role[2i+1:2i]`.
- R3: On `rd_frame` with a ready buffer present, that buffer becomes showing and `rd_idx` takes its index. The previously shown buffer, if any, becomes free.
- R4: On `rd_frame` with no ready buffer, roles, `rd_idx` and `rd_valid` keep their values.
- R5: On `wr_done` with a free buffer present, the filling buffer becomes ready, the free buffer becomes filling, and `wr_idx` takes its index.
- R6: On `wr_done` with no free buffer, roles and `wr_idx` keep their values, so the writer overwrites its buffer.
- R7: When several buffers qualify for promotion, the lowest index is taken.
- R8: `rd_valid` stays 0 and `rd_idx` stays 0 until the first promotion to showing. After that, `rd_valid` stays 1 until reset.
- R9: When both pulses arrive in the same cycle, the reader hand-over is applied first. The writer hand-over then sees the updated roles, so it may take the buffer just freed.
- R10: At every edge exactly one buffer is filling and at most one is showing. While `rd_valid` is 1, `wr_idx` differs from `rd_idx`.
- R11: Pulses are sampled at the rising edge and every output is registered. Outputs change one cycle after the pulse, and a cycle with no pulse changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_done | input | 1 | One-cycle pulse: writer finished a full frame |
| rd_frame | input | 1 | One-cycle pulse: reader frame boundary |
| wr_idx | output | 2 | Buffer the writer must fill |
| rd_idx | output | 2 | Buffer the reader must show |
| rd_valid | output | 1 | A complete frame has been handed to the reader |
| buf_role | output | 6 | Role code of each buffer, 2 bits per buffer |

## Verification
A directed sequence first fills two buffers before the first display, so two are ready at once. This separates lowest-index choice from any other order and exercises the writer overwrite case when no buffer is free. Reader boundaries with nothing ready check that the displayed frame repeats and that the valid flag stays low before the first frame. A cycle with both pulses checks that the writer takes the buffer the reader just released, which tells the reader-first order apart from writer-first. A long run with independent random pulse densities on both sides is then compared cycle by cycle against a role model, while the one-writer, single-display and distinct-index rules are checked on the outputs.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    localparam int NBUF  = 3;
    localparam int IDX_W = $clog2(NBUF);

    typedef enum logic [1:0] {
        ROLE_FREE  = 2'b00,
        ROLE_FILL  = 2'b01,
        ROLE_SHOW  = 2'b10,
        ROLE_READY = 2'b11
    } role_e;

    typedef role_e [NBUF-1:0] roles_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [NBUF-1:0] role_mask(input roles_t r, input role_e k);
        logic [NBUF-1:0] m;
        for (int i = 0; i < NBUF; i++) begin
            m[i] = (r[i] == k);
        end
        return m;
    endfunction

endpackage

// File: rtl/tfb_first_match.sv
module tfb_first_match
    import tfb_pkg::*;
(
    input  roles_t roles,
    input  role_e  want,
    output pick_t  pick
);
    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        pick = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (roles[i] == want) begin
                pick.hit = 1'b1;
                pick.idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tfb_reader_stage.sv
module tfb_reader_stage
    import tfb_pkg::*;
(
    input  logic             rd_frame,
    input  roles_t           roles_i,
    input  logic [IDX_W-1:0] show_idx_i,
    input  logic             show_vld_i,
    output roles_t           roles_o,
    output logic [IDX_W-1:0] show_idx_o,
    output logic             show_vld_o
);
    pick_t ready_pick;

    tfb_first_match u_find_ready (
        .roles (roles_i),
        .want  (ROLE_READY),
        .pick  (ready_pick)
    );

    always_comb begin
        roles_o    = roles_i;
        show_idx_o = show_idx_i;
        show_vld_o = show_vld_i;
        if (rd_frame && ready_pick.hit) begin
            if (show_vld_i) begin
                roles_o[show_idx_i] = ROLE_FREE;
            end
            roles_o[ready_pick.idx] = ROLE_SHOW;
            show_idx_o              = ready_pick.idx;
            show_vld_o              = 1'b1;
        end
    end
endmodule

// File: rtl/tfb_writer_stage.sv
module tfb_writer_stage
    import tfb_pkg::*;
(
    input  logic             wr_done,
    input  roles_t           roles_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    output roles_t           roles_o,
    output logic [IDX_W-1:0] fill_idx_o
);
    pick_t free_pick;

    tfb_first_match u_find_free (
        .roles (roles_i),
        .want  (ROLE_FREE),
        .pick  (free_pick)
    );

    always_comb begin
        roles_o    = roles_i;
        fill_idx_o = fill_idx_i;
        if (wr_done && free_pick.hit) begin
            roles_o[fill_idx_i]    = ROLE_READY;
            roles_o[free_pick.idx] = ROLE_FILL;
            fill_idx_o             = free_pick.idx;
        end
    end
endmodule

// File: rtl/tribuf_rotator.sv
module tribuf_rotator
    import tfb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_done,
    input  logic                   rd_frame,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [IDX_W-1:0]       rd_idx,
    output logic                   rd_valid,
    output logic [2*NBUF-1:0]      buf_role
);
    roles_t           roles_q;
    logic [IDX_W-1:0] fill_q, show_q;
    logic             vld_q;

    roles_t           roles_mid, roles_nx;
    logic [IDX_W-1:0] show_nx, fill_nx;
    logic             vld_nx;

    // reader hand-over first, writer sees its result (same-cycle order)
    tfb_reader_stage u_rd (
        .rd_frame   (rd_frame),
        .roles_i    (roles_q),
        .show_idx_i (show_q),
        .show_vld_i (vld_q),
        .roles_o    (roles_mid),
        .show_idx_o (show_nx),
        .show_vld_o (vld_nx)
    );

    tfb_writer_stage u_wr (
        .wr_done    (wr_done),
        .roles_i    (roles_mid),
        .fill_idx_i (fill_q),
        .roles_o    (roles_nx),
        .fill_idx_o (fill_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) begin
                roles_q[i] <= (i == 0) ? ROLE_FILL : ROLE_FREE;
            end
            fill_q <= '0;
            show_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            roles_q <= roles_nx;
            fill_q  <= fill_nx;
            show_q  <= show_nx;
            vld_q   <= vld_nx;
        end
    end

    assign wr_idx   = fill_q;
    assign rd_idx   = show_q;
    assign rd_valid = vld_q;
    assign buf_role = roles_q;

    logic [NBUF-1:0] m_fill, m_show, m_ready, m_free;
    assign m_fill  = role_mask(roles_q, ROLE_FILL);
    assign m_show  = role_mask(roles_q, ROLE_SHOW);
    assign m_ready = role_mask(roles_q, ROLE_READY);
    assign m_free  = role_mask(roles_q, ROLE_FREE);

    AST_ONE_FILLING: assert property (@(posedge clk) disable iff (rst)
        $countones(m_fill) == 1); // R10
    AST_SHOW_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_show)); // R10
    AST_IDX_APART: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (wr_idx != rd_idx)); // R10
    AST_WR_OWNS_FILL: assert property (@(posedge clk) disable iff (rst)
        m_fill[wr_idx]); // R5
    AST_RD_OWNS_SHOW: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> m_show[rd_idx]); // R3
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> rd_valid); // R8
    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_idx == '0 && m_show == '0)); // R8
    AST_NO_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_frame && m_ready == '0) |=> $stable(rd_idx)); // R4
    AST_NO_FREE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !rd_frame && m_free == '0) |=> $stable(wr_idx)); // R6
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_done && !rd_frame) |=> $stable(buf_role)); // R11

endmodule

// File: tb/tribuf_rotator_tb_top.sv
module tribuf_rotator_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_done = 1'b0;
    logic       rd_frame = 1'b0;
    logic [1:0] wr_idx, rd_idx;
    logic       rd_valid;
    logic [5:0] buf_role;

    always #(CLK_P/2) clk = ~clk;

    tribuf_rotator dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_done  (wr_done),
        .rd_frame (rd_frame),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .buf_role (buf_role)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [5:0] roles;
        logic [1:0] wr;
        logic [1:0] rd;
        logic       v;
        string      tag;
    } exp_t;

    exp_t q[$];

    // reference model of roles: 00 free, 01 filling, 10 showing, 11 ready
    logic [1:0] m_role [3];
    logic [1:0] m_wr, m_rd;
    logic       m_v;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_role[0] = 2'b01; m_role[1] = 2'b00; m_role[2] = 2'b00;
        m_wr = 0; m_rd = 0; m_v = 0;
    endtask

    task automatic model_apply(input logic w, input logic r);
        int f;
        if (r) begin
            f = -1;
            for (int i = 2; i >= 0; i--) if (m_role[i] == 2'b11) f = i;
            if (f >= 0) begin
                if (m_v) m_role[m_rd] = 2'b00;
                m_role[f] = 2'b10;
                m_rd = 2'(f);
                m_v = 1;
            end
        end
        if (w) begin
            f = -1;
            for (int i = 2; i >= 0; i--) if (m_role[i] == 2'b00) f = i;
            if (f >= 0) begin
                m_role[m_wr] = 2'b11;
                m_role[f] = 2'b01;
                m_wr = 2'(f);
            end
        end
    endtask

    task automatic step(input logic w, input logic r, input string tag);
        exp_t e;
        @(negedge clk);
        wr_done  = w;
        rd_frame = r;
        model_apply(w, r);
        e.roles = {m_role[2], m_role[1], m_role[0]};
        e.wr = m_wr; e.rd = m_rd; e.v = m_v; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: one item per clock after each driven step
    initial begin
        exp_t e;
        int nf, ns;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.tag, "buf_role", buf_role, e.roles);
                chk(e.tag, "wr_idx", wr_idx, e.wr);
                chk(e.tag, "rd_idx", rd_idx, e.rd);
                chk(e.tag, "rd_valid", rd_valid, e.v);
                nf = 0; ns = 0;
                for (int i = 0; i < 3; i++) begin
                    if (buf_role[2*i +: 2] == 2'b01) nf++;
                    if (buf_role[2*i +: 2] == 2'b10) ns++;
                end
                chk("R10", "filling count", nf, 1);
                chk("R10", "showing at most one", (ns <= 1), 1);
                if (rd_valid) chk("R10", "wr_idx differs from rd_idx", (wr_idx != rd_idx), 1);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 / R2: reset state, buffer 0 filling code 01 at bits 1:0
        chk("R1", "buf_role", buf_role, 6'b00_00_01);
        chk("R1", "wr_idx", wr_idx, 0);
        chk("R1", "rd_idx", rd_idx, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R2", "buffer0 code", buf_role[1:0], 2'b01);
        rst = 1'b0;

        step(0, 1, "R4_R8 boundary with nothing ready");
        step(0, 0, "R11 idle cycle");
        step(1, 0, "R5 first frame done");
        step(1, 0, "R5 second frame done");
        step(1, 0, "R6 no free buffer, overwrite");
        step(0, 1, "R7_R3 lowest ready shown first");
        step(0, 1, "R3 next ready shown, old freed");
        step(0, 1, "R4 repeat frame");
        step(1, 1, "R5 both pulses, nothing ready");
        step(1, 0, "R6 no free buffer");
        step(1, 1, "R9 writer takes buffer freed by reader");
        step(0, 0, "R11 idle after swap");

        for (int n = 0; n < 3000; n++) begin
            int pw, pr;
            pw = (n / 500) % 3;
            pr = (n / 700) % 3;
            step(($urandom % (2 + pw)) == 0, ($urandom % (2 + pr * 2)) == 0, "R10 random rates");
        end
        @(negedge clk);
        wr_done = 0; rd_frame = 0;
        while (q.size() > 0) @(negedge clk);

        // R1: reset mid-run returns to initial roles
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "buf_role after mid reset", buf_role, 6'b00_00_01);
        chk("R1", "rd_valid after mid reset", rd_valid, 0);
        chk("R1", "wr_idx after mid reset", wr_idx, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule